// File: doc/BRIEF.md
# Chip Memory Byte-Strobe Generator

This block turns the shared row and column timing pulses of a display bus controller into the select strobes for a 32-bit DRAM array. The array has two banks, and each bank uses 9-bit row and column addresses, which gives 2 MB in all. A row strobe goes only to the bank that the bank address bit selects. The column strobe is split into four byte lanes. On processor cycles the lanes come from the low two address bits and the transfer-size code, which gives byte-level write control.

Chip-bus cycles are 16 bits wide and can land on either half of the 32-bit memory bus. When a chip cycle targets the upper half, the block raises a bridge enable so that the low half of the bus is copied onto the high half. It then opens only the two upper lanes, so the two halves never drive against each other. During column-before-row refresh, every row and column strobe follows its timing pulse, whatever the cycle attributes are. A read-latch enable marks processor read cycles, so that read data can be held long enough for the processor's hold time.

All strobes are active low. They are registered and follow their inputs one clock later.

Top module: `chipmem_strobe_gen`

## Requirements
- R1: While `rst_n` is low, every `ras_n` and `cas_n` bit is 1 and `bridge_en` and `rd_latch_en` are 0, and this takes effect without waiting for a clock edge.
- R2: Every output is registered and shows the inputs sampled at the previous rising clock edge. Between that edge and the next one the outputs do not change.
- R3: Outside refresh, `ras_n[b]` is 0 only when `ras_tmg_n` is 0 and `bank_sel` equals b. At most one `ras_n` bit is 0.
- R4: On a processor write (`cpu_cycle`=1, `rd_not_wr`=0) with `cas_tmg_n`=0, the enabled lanes start at the lane given by `byte_adr` and cover n lanes, stopping after lane 3. The count n comes from `xfer_size`: 00 = 4, 01 = 1, 10 = 2, 11 = 3. Lane k is `cas_n[k]`, and lane 0 carries D31:24.
- R5: On a processor read with `cas_tmg_n`=0, all four `cas_n` bits are 0.
- R6: On a chip cycle (`cpu_cycle`=0) with `cas_tmg_n`=0, both lanes of one half are enabled. `byte_adr[1]`=0 selects lanes 0 and 1, and `byte_adr[1]`=1 selects lanes 2 and 3. `byte_adr[0]` and `xfer_size` are ignored.
- R7: When a chip cycle targets the upper half and `ras_tmg_n` or `cas_tmg_n` is 0, `bridge_en` is 1. While `bridge_en` is 1, lanes 2 and 3 stay at 1.
- R8: When `refresh`=1, both `ras_n` bits follow `ras_tmg_n` and all four `cas_n` bits follow `cas_tmg_n`. `bridge_en` and `rd_latch_en` are 0, and the bank, address, size and direction inputs are ignored.
- R9: `rd_latch_en` is 1 exactly for a processor read outside refresh with `cas_tmg_n`=0.
- R10: When `cas_tmg_n` is 1, all `cas_n` bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_tmg_n | input | 1 | Row timing pulse, active low |
| cas_tmg_n | input | 1 | Column timing pulse, active low |
| bank_sel | input | BANK_W | Bank address |
| byte_adr | input | 2 | Low byte address bits |
| xfer_size | input | 2 | Transfer-size code |
| rd_not_wr | input | 1 | 1 = read, 0 = write |
| cpu_cycle | input | 1 | 1 = processor cycle, 0 = 16-bit chip cycle |
| refresh | input | 1 | Refresh cycle flag |
| ras_n | output | NUM_BANKS | Per-bank row strobes, active low |
| cas_n | output | 4 | Per-lane column strobes, active low; bit 0 is D31:24 |
| bridge_en | output | 1 | Copy the low half of the bus onto the high half |
| rd_latch_en | output | 1 | Hold processor read data |

## Verification
Two functions can fall in the same cycle. Bridging and the lane decode can both be active on one chip cycle, and refresh can take over the strobes while the access attributes still point at a bank, an address and a size. The stimulus table places chip cycles aimed at the upper half next to cycles aimed at the lower half. For these, the bench checks that the bridge enable and the upper-lane strobes appear together and that the lower lanes stay closed. Refresh vectors carry live bank, address, size and direction values, and they are judged correct only when every strobe follows its timing pulse and the bridge and latch enables stay low.

// File: rtl/chipmem_pkg.sv
package chipmem_pkg;
    localparam int LANES = 4;
    localparam int ADR_W = 2;

    typedef enum logic [1:0] {
        SZ_LONG   = 2'b00,
        SZ_BYTE   = 2'b01,
        SZ_WORD   = 2'b10,
        SZ_TRIPLE = 2'b11
    } xfer_size_e;

    // Number of bytes moved by a transfer-size code.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        return (sz == SZ_LONG) ? 3'd4 : {1'b0, sz};
    endfunction
endpackage

// File: rtl/chipmem_cpu_lanes.sv
module chipmem_cpu_lanes
    import chipmem_pkg::*;
(
    input  logic [ADR_W-1:0] byte_adr,
    input  logic [1:0]       xfer_size,
    input  logic             is_read,
    output logic [LANES-1:0] lane_en
);
    logic [2:0] first_lane;
    logic [2:0] end_lane;

    assign first_lane = {1'b0, byte_adr};
    assign end_lane   = first_lane + size_bytes(xfer_size);

    // Lane k is open from the addressed byte up to the last byte moved;
    // lanes past 3 do not exist, so the span is cut at the word boundary.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_en[k] = is_read ||
                            ((3'(k) >= first_lane) && (3'(k) < end_lane));
    end
endmodule

// File: rtl/chipmem_chip_half.sv
module chipmem_chip_half
    import chipmem_pkg::*;
(
    input  logic             low_half,
    output logic [LANES-1:0] lane_en,
    output logic             bridge_req
);
    localparam int HALF = LANES / 2;

    // Lanes below HALF carry the upper data bits.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k < HALF) begin : g_up
            assign lane_en[k] = !low_half;
        end else begin : g_lo
            assign lane_en[k] = low_half;
        end
    end

    assign bridge_req = !low_half;
endmodule

// File: rtl/chipmem_bank_dec.sv
module chipmem_bank_dec #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic                 all_banks,
    output logic [NUM_BANKS-1:0] bank_hit
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_hit[b] = all_banks || (bank_sel == BANK_W'(b));
    end
endmodule

// File: rtl/chipmem_strobe_gen.sv
module chipmem_strobe_gen
    import chipmem_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ras_tmg_n,
    input  logic                 cas_tmg_n,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic [ADR_W-1:0]     byte_adr,
    input  logic [1:0]           xfer_size,
    input  logic                 rd_not_wr,
    input  logic                 cpu_cycle,
    input  logic                 refresh,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic [LANES-1:0]     cas_n,
    output logic                 bridge_en,
    output logic                 rd_latch_en
);
    typedef struct packed {
        logic [NUM_BANKS-1:0] ras_n;
        logic [LANES-1:0]     cas_n;
        logic                 bridge;
        logic                 rd_latch;
    } strobe_t;

    localparam strobe_t IDLE = '{ras_n: '1, cas_n: '1, bridge: 1'b0, rd_latch: 1'b0};

    strobe_t state_d, state_q;

    logic [NUM_BANKS-1:0] bank_hit;
    logic [LANES-1:0]     cpu_lanes;
    logic [LANES-1:0]     chip_lanes;
    logic                 chip_bridge;

    chipmem_bank_dec #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_bank_dec (
        .bank_sel  (bank_sel),
        .all_banks (refresh),
        .bank_hit  (bank_hit)
    );

    chipmem_cpu_lanes u_cpu_lanes (
        .byte_adr  (byte_adr),
        .xfer_size (xfer_size),
        .is_read   (rd_not_wr),
        .lane_en   (cpu_lanes)
    );

    chipmem_chip_half u_chip_half (
        .low_half   (byte_adr[1]),
        .lane_en    (chip_lanes),
        .bridge_req (chip_bridge)
    );

    always_comb begin
        logic             ras_act;
        logic             cas_act;
        logic [LANES-1:0] lanes;

        ras_act = !ras_tmg_n;
        cas_act = !cas_tmg_n;
        state_d = IDLE;

        // Refresh opens every bank and every lane.
        lanes = refresh ? '1 : (cpu_cycle ? cpu_lanes : chip_lanes);

        state_d.ras_n    = ~(bank_hit & {NUM_BANKS{ras_act}});
        state_d.cas_n    = ~(lanes & {LANES{cas_act}});
        state_d.bridge   = !refresh && !cpu_cycle && chip_bridge && (ras_act || cas_act);
        state_d.rd_latch = !refresh && cpu_cycle && rd_not_wr && cas_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE;
        else        state_q <= state_d;
    end

    assign ras_n       = state_q.ras_n;
    assign cas_n       = state_q.cas_n;
    assign bridge_en   = state_q.bridge;
    assign rd_latch_en = state_q.rd_latch;
endmodule

// File: rtl/chipmem_strobe_gen_chk.sv
module chipmem_strobe_gen_chk
    import chipmem_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ras_tmg_n,
    input logic                 cas_tmg_n,
    input logic [BANK_W-1:0]    bank_sel,
    input logic [ADR_W-1:0]     byte_adr,
    input logic [1:0]           xfer_size,
    input logic                 rd_not_wr,
    input logic                 cpu_cycle,
    input logic                 refresh,
    input logic [NUM_BANKS-1:0] ras_n,
    input logic [LANES-1:0]     cas_n,
    input logic                 bridge_en,
    input logic                 rd_latch_en
);
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(refresh)) |-> $onehot0(~ras_n)); // R3

    AST_BYTE_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_cycle) && !$past(rd_not_wr) && !$past(refresh)
         && ($past(xfer_size) == 2'b01)) |-> ($countones(~cas_n) <= 1)); // R4

    AST_CPU_READ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_cycle) && $past(rd_not_wr) && !$past(refresh)
         && !$past(cas_tmg_n)) |-> (cas_n == '0)); // R5

    AST_CHIP_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cpu_cycle) && !$past(refresh))
        |-> ((cas_n[0] == cas_n[1]) && (cas_n[2] == cas_n[3])
             && (&cas_n[1:0] || &cas_n[3:2]))); // R6

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_en |-> (&cas_n[3:2])); // R7

    AST_REFRESH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(refresh))
        |-> ((ras_n == {NUM_BANKS{$past(ras_tmg_n)}}) && (cas_n == {LANES{$past(cas_tmg_n)}})
             && !bridge_en && !rd_latch_en)); // R8

    AST_LATCH_ONLY_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_latch_en |-> (cas_n == '0)); // R9

    AST_NO_STRAY_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cas_tmg_n)) |-> (&cas_n)); // R10
endmodule

bind chipmem_strobe_gen chipmem_strobe_gen_chk #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_tmg_n(ras_tmg_n), .cas_tmg_n(cas_tmg_n),
    .bank_sel(bank_sel), .byte_adr(byte_adr), .xfer_size(xfer_size),
    .rd_not_wr(rd_not_wr), .cpu_cycle(cpu_cycle), .refresh(refresh),
    .ras_n(ras_n), .cas_n(cas_n), .bridge_en(bridge_en), .rd_latch_en(rd_latch_en)
);

// File: tb/chipmem_strobe_gen_bench.sv
module chipmem_strobe_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_tmg_n = 1'b1;
    logic       cas_tmg_n = 1'b1;
    logic [0:0] bank_sel = '0;
    logic [1:0] byte_adr = '0;
    logic [1:0] xfer_size = '0;
    logic       rd_not_wr = 1'b1;
    logic       cpu_cycle = 1'b1;
    logic       refresh = 1'b0;
    logic [1:0] ras_n;
    logic [3:0] cas_n;
    logic       bridge_en;
    logic       rd_latch_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chipmem_strobe_gen u_chipmem_strobe_gen (
        .clk(clk), .rst_n(rst_n), .ras_tmg_n(ras_tmg_n), .cas_tmg_n(cas_tmg_n),
        .bank_sel(bank_sel), .byte_adr(byte_adr), .xfer_size(xfer_size),
        .rd_not_wr(rd_not_wr), .cpu_cycle(cpu_cycle), .refresh(refresh),
        .ras_n(ras_n), .cas_n(cas_n), .bridge_en(bridge_en), .rd_latch_en(rd_latch_en)
    );

    // {req[3:0], refresh, cpu, rd, bank, adr[1:0], siz[1:0], ras_t_n, cas_t_n,
    //  exp ras_n[1:0], exp cas_n[3:0], exp bridge, exp latch}
    // cas_n is written bit 3 .. bit 0; bit 0 is lane 0 (D31:24).
    localparam int NV = 17;
    localparam logic [21:0] VEC [NV] = '{
        22'b1010_0_1_1_0_00_00_1_1_11_1111_0_0, // R10 idle, no strobes
        22'b0011_0_1_1_0_00_00_0_1_10_1111_0_0, // R3 bank 0 row only
        22'b0101_0_1_1_1_10_01_0_0_01_0000_0_1, // R5 cpu read bank 1, all lanes, latch (R9)
        22'b0100_0_1_0_0_00_00_0_0_10_0000_0_0, // R4 long write at 0
        22'b0100_0_1_0_0_10_01_0_0_10_1011_0_0, // R4 byte write at 2
        22'b0100_0_1_0_1_01_10_0_0_01_1001_0_0, // R4 word write at 1
        22'b0100_0_1_0_0_11_11_0_0_10_0111_0_0, // R4 three bytes at 3, clipped
        22'b0100_0_1_0_0_10_00_0_0_10_0011_0_0, // R4 long at 2, clipped
        22'b0100_0_1_0_0_00_11_0_0_10_1000_0_0, // R4 three bytes at 0
        22'b0100_0_1_0_0_11_10_0_0_10_0111_0_0, // R4 word at 3, clipped
        22'b0111_0_0_1_0_01_01_0_0_10_1100_1_0, // R7 chip read upper half, bridge
        22'b0110_0_0_1_1_10_00_0_0_01_0011_0_0, // R6 chip read lower half
        22'b0110_0_0_0_0_00_01_0_0_10_1100_1_0, // R6 chip write upper half, size ignored
        22'b0111_0_0_1_0_00_00_0_1_10_1111_1_0, // R7 chip row only, bridge already open
        22'b1000_1_1_0_1_11_01_1_0_11_0000_0_0, // R8 refresh column first
        22'b1000_1_0_1_0_00_00_0_0_00_0000_0_0, // R8 refresh both
        22'b1000_1_1_1_0_01_10_0_1_00_1111_0_0  // R8 refresh row, no latch
    };

    function automatic logic [7:0] outs();
        return {ras_n, cas_n, bridge_en, rd_latch_en};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [9:0] v);
        {refresh, cpu_cycle, rd_not_wr, bank_sel, byte_adr, xfer_size, ras_tmg_n, cas_tmg_n} = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset idle", outs(), 8'b11_1111_0_0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][17:8]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][21:18], i), outs(), VEC[i][7:0]);
        end

        // R2: the output holds until the next rising edge, then takes the new value.
        drive(10'b0_1_1_0_00_00_1_1);
        @(negedge clk);
        drive(10'b0_1_1_0_00_00_0_0);
        #5;
        check("R2 before edge", outs(), 8'b11_1111_0_0);
        @(negedge clk);
        check("R2 after edge", outs(), 8'b10_0000_0_1);

        // R1: an asynchronous reset in the middle of an active cycle.
        #3 rst_n = 1'b0;
        #1;
        check("R1 async reset", outs(), 8'b11_1111_0_0);
        @(negedge clk);
        check("R1 held in reset", outs(), 8'b11_1111_0_0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 resume after reset", outs(), 8'b10_0000_0_1);

        // R6: byte_adr[0] is ignored on a chip cycle.
        drive(10'b0_0_0_1_11_01_0_0);
        @(negedge clk);
        check("R6 low half, a0 ignored", outs(), 8'b01_0011_0_0);

        // R10: column pulse released on a processor write.
        drive(10'b0_1_0_0_00_00_0_1);
        @(negedge clk);
        check("R10 row only write", outs(), 8'b10_1111_0_0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule